// File: doc/BRIEF.md
# Two-Bank SDRAM Controller

This block sits between a simple host request port and a 16 Mbit, x16 SDRAM device with two internal banks. The host presents one request at a time with a valid/ready handshake. Each request is either a single-word write with per-byte enables or a burst read that returns a fixed number of sequential words. The controller turns every request into a closed-page command sequence on the memory pins: activate the row, issue the column command, then precharge the bank. Read data comes back on a strobed return port.

After reset the controller runs the device start-up sequence. It waits a configurable number of idle cycles, precharges all banks, issues two auto refresh commands and then loads the mode register. Only then does it open the host port. During normal operation a free-running interval timer asks for an auto refresh about every 15.6 µs. The refresh is served once the access in flight completes, and it takes precedence over any waiting host request. Timing constants, CAS latency and burst length are elaboration-time parameters. A configuration that pairs CAS latency 2 with a clock above 100 MHz is rejected at elaboration.

Top module: `sdram_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sd_cke` is 0 in reset, the pins carry NOP, `req_ready` is 0 and `rd_valid` is 0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n}:
  - NOP = 0111
  - ACTIVATE = 0011
  - READ = 0101
  - WRITE = 0100
  - PRECHARGE = 0010
  - REFRESH = 0001
  - MODE SET = 0000

  After reset, at least INIT_WAIT NOP cycles pass. The first commands are then, in order: PRECHARGE with address bit 10 set (all banks), REFRESH, REFRESH, MODE SET. `req_ready` stays low until all four have been issued.
- R3: The mode word on `sd_addr` carries these fields. All other bits are 0 and `sd_ba` is 0.
  - Bits 2:0 hold the burst-length code (1→0, 2→1, 4→2, 8→3).
  - Bit 3 is 0 for sequential order.
  - Bits 6:4 hold the CAS latency.
  - Bit 9 is 1 for single-location writes.
- R4: The host address is {bank[19], row[18:8], column[7:0]}. ACTIVATE carries the bank on `sd_ba` and the row on `sd_addr`. READ and WRITE carry the same bank, the column in `sd_addr[7:0]`, and `sd_addr[10]` = 0.
- R5: A READ or WRITE is issued at least T_RCD cycles after the ACTIVATE of its bank.
- R6: A write is one beat. `sd_dq_oe` is 1 only in the WRITE cycle, in which `sd_dq_out` holds the write data and `sd_dqm` = ~`req_be` (`sd_dqm[1]` masks bits 15:8).
- R7: A PRECHARGE comes at least T_RDL cycles after the last WRITE. An ACTIVATE comes at least T_RP cycles after the PRECHARGE before it.
- R8: A read returns exactly BL words on `rd_valid`, in sequential order within the aligned burst. The first word is raised CL+1 cycles after the READ appears on the pins.
- R9: Once running, REFRESH commands recur every REF_INTERVAL cycles, within a slack of 40 cycles. Each REFRESH is preceded by an all-bank PRECHARGE at least T_RP cycles earlier, with no ACTIVATE in between.
- R10: While a refresh is pending, `req_ready` is 0. A host that requests back to back does not hold off refresh beyond the R9 bound.
- R11: A write whose byte enable is 0 for a byte leaves that byte of the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | {bank, row, column} word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for the write |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Multiplexed row/column/mode address |
| sd_dq_out | output | 16 | Data driven toward the device |
| sd_dq_oe | output | 1 | Output enable for the data pins |
| sd_dq_in | input | 16 | Data received from the device |
| sd_dqm | output | 2 | Byte masks, bit 1 = upper byte |

## Verification
The bench runs a cycle-level device model and keeps its own shadow of the written words. It goes after the partial-byte writes and the all-masked write. A controller with a swapped or inverted DQM would corrupt the wrong byte. The CAS-latency capture point is checked to the cycle, since capturing one cycle early or late shifts every burst by a word. Command spacings are measured on every access, so a precharge placed one cycle after a write (tRDL) or a column command that comes too soon after activation is caught. A long run of back-to-back reads checks that refresh still wins arbitration; a controller that lets host traffic starve it would stretch the refresh interval past its bound.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (en) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CL = 3,
  parameter int BL = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int L = CL + BL - 1;

  logic [L-1:0] inflight;
  logic         hit;

  assign hit = |inflight[CL-1 +: BL];

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      inflight <= {inflight[L-2:0], rd_issue};
      rd_valid <= hit;
      if (hit) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdr_pkg::*;
#(
  parameter int DW           = 16,
  parameter int BA_W         = 1,
  parameter int ROW_W        = 11,
  parameter int COL_W        = 8,
  parameter int CL           = 3,
  parameter int BL           = 4,
  parameter int CLK_MHZ      = 125,
  parameter int INIT_WAIT    = 25000,
  parameter int REF_INTERVAL = 1950,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 6,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2,
  parameter int T_RDL        = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_we,
  input  logic [BA_W+ROW_W+COL_W-1:0]  req_addr,
  input  logic [DW-1:0]                req_wdata,
  input  logic [DW/8-1:0]              req_be,
  output logic                         rd_valid,
  output logic [DW-1:0]                rd_data,
  output logic                         sd_cke,
  output logic                         sd_cs_n,
  output logic                         sd_ras_n,
  output logic                         sd_cas_n,
  output logic                         sd_we_n,
  output logic [BA_W-1:0]              sd_ba,
  output logic [ROW_W-1:0]             sd_addr,
  output logic [DW-1:0]                sd_dq_out,
  output logic                         sd_dq_oe,
  input  logic [DW-1:0]                sd_dq_in,
  output logic [DW/8-1:0]              sd_dqm
);
  localparam int BE_W    = DW / 8;
  localparam int AP_BIT  = 10;
  localparam int WR_WAIT = max2(T_RDL, T_RAS - T_RCD);
  localparam int RD_WAIT = max2(CL + BL, T_RAS - T_RCD);
  localparam int CNT_MAX = max2(INIT_WAIT, max2(T_RFC, max2(RD_WAIT,
                           max2(WR_WAIT, max2(T_RP, max2(T_RCD, T_MRD))))));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({1'b1, 2'b00, 3'(CL), 1'b0, burst_code(BL)});

  generate
    if (!(CL == 2 || CL == 3) || (CL == 2 && CLK_MHZ > 100) ||
        !(BL == 1 || BL == 2 || BL == 4 || BL == 8) || ROW_W < 11) begin : g_cfg_bad
      $error("sdram_ctrl: unsupported CL, BL, clock rate or address width");
    end
  endgenerate

  typedef enum logic [3:0] {
    S_WAIT, S_IPRE, S_IREF1, S_IREF2, S_IMRS, S_IDLE,
    S_ACT, S_RW, S_PRE, S_FPRE, S_FREF
  } state_e;

  state_e               state, nxt;
  logic [CNT_W-1:0]     cnt;
  logic                 init_done;
  logic                 ref_pend;
  logic                 ref_ack;
  sdr_cmd_e             cmd_q;
  logic                 we_q;
  logic [BA_W-1:0]      ba_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic [DW-1:0]        wdata_q;
  logic [BE_W-1:0]      be_q;

  assign req_ready = (state == S_IDLE) && !ref_pend;
  assign ref_ack   = (state == S_FREF);
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk (clk),
    .rst (rst),
    .en  (init_done),
    .ack (ref_ack),
    .pend(ref_pend)
  );

  sdr_rd_capture #(.CL(CL), .BL(BL), .DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .rd_issue(cmd_q == CMD_RD),
    .dq_in   (sd_dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_WAIT;
      nxt       <= S_IPRE;
      cnt       <= CNT_W'(INIT_WAIT - 2);
      init_done <= 1'b0;
      sd_cke    <= 1'b0;
      cmd_q     <= CMD_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dqm    <= '1;
      we_q      <= 1'b0;
      ba_q      <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
    end else begin
      sd_cke   <= 1'b1;
      cmd_q    <= CMD_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      case (state)
        S_WAIT: begin
          if (cnt == '0) state <= nxt;
          else           cnt   <= cnt - 1'b1;
        end
        S_IPRE, S_FPRE: begin
          cmd_q           <= CMD_PRE;
          sd_addr         <= '0;
          sd_addr[AP_BIT] <= 1'b1;
          cnt             <= CNT_W'(T_RP - 2);
          nxt             <= (state == S_IPRE) ? S_IREF1 : S_FREF;
          state           <= S_WAIT;
        end
        S_IREF1, S_IREF2, S_FREF: begin
          cmd_q <= CMD_REF;
          cnt   <= CNT_W'(T_RFC - 2);
          nxt   <= (state == S_IREF1) ? S_IREF2 :
                   (state == S_IREF2) ? S_IMRS : S_IDLE;
          state <= S_WAIT;
        end
        S_IMRS: begin
          cmd_q   <= CMD_MRS;
          sd_ba   <= '0;
          sd_addr <= MODE_WORD;
          cnt     <= CNT_W'(T_MRD - 2);
          nxt     <= S_IDLE;
          state   <= S_WAIT;
        end
        S_IDLE: begin
          init_done <= 1'b1;
          if (ref_pend) begin
            state <= S_FPRE;
          end else if (req_valid) begin
            we_q    <= req_we;
            {ba_q, row_q, col_q} <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            state   <= S_ACT;
          end
        end
        S_ACT: begin
          cmd_q   <= CMD_ACT;
          sd_ba   <= ba_q;
          sd_addr <= row_q;
          cnt     <= CNT_W'(T_RCD - 2);
          nxt     <= S_RW;
          state   <= S_WAIT;
        end
        S_RW: begin
          sd_ba   <= ba_q;
          sd_addr <= ROW_W'(col_q);
          nxt     <= S_PRE;
          state   <= S_WAIT;
          if (we_q) begin
            cmd_q     <= CMD_WR;
            sd_dq_out <= wdata_q;
            sd_dq_oe  <= 1'b1;
            sd_dqm    <= ~be_q;
            cnt       <= CNT_W'(WR_WAIT - 2);
          end else begin
            cmd_q <= CMD_RD;
            cnt   <= CNT_W'(RD_WAIT - 2);
          end
        end
        S_PRE: begin
          cmd_q   <= CMD_PRE;
          sd_ba   <= ba_q;
          sd_addr <= '0;
          cnt     <= CNT_W'(T_RP - 2);
          nxt     <= S_IDLE;
          state   <= S_WAIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RDL = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd,
  input logic       req_ready,
  input logic       ref_pend,
  input logic       dq_oe,
  input logic       rd_valid
);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  logic [7:0] since_act, since_pre, since_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= 8'hFF;
      since_pre <= 8'hFF;
      since_wr  <= 8'hFF;
    end else begin
      since_act <= (cmd == C_ACT) ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
      since_pre <= (cmd == C_PRE) ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
      since_wr  <= (cmd == C_WR)  ? 8'd1 : (since_wr  == 8'hFF ? since_wr  : since_wr  + 8'd1);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd == C_NOP && !req_ready && !rd_valid)); // R1

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (cmd == C_WR)); // R6

  AST_TRCD: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_RD || cmd == C_WR) |-> (int'(since_act) >= T_RCD)); // R5

  AST_TRDL: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_PRE) |-> (int'(since_wr) >= T_RDL)); // R7

  AST_TRP: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |-> (int'(since_pre) >= T_RP)); // R7

  AST_REF_AFTER_PREALL: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF) |-> (int'(since_pre) >= T_RP && since_act > since_pre)); // R9

  AST_REF_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    ref_pend |-> !req_ready); // R10
endmodule

bind sdram_ctrl sdram_ctrl_chk #(
  .T_RCD(T_RCD),
  .T_RP (T_RP),
  .T_RDL(T_RDL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .req_ready(req_ready),
  .ref_pend (ref_pend),
  .dq_oe    (sd_dq_oe),
  .rd_valid (rd_valid)
);

// File: tb/sdram_ctrl_tb.sv
module sdram_ctrl_tb;
  localparam int CL = 3, BL = 4, INIT_WAIT = 50, REF_INTERVAL = 1950;
  localparam int T_RCD = 3, T_RP = 3, T_RDL = 2, SLACK = 40;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  localparam int NV = 14;
  // {we, addr[19:0], data[15:0], be[1:0]}
  localparam logic [38:0] VEC [0:NV-1] = '{
    {1'b1, 20'h00510, 16'h1111, 2'b11},
    {1'b1, 20'h00511, 16'h2222, 2'b11},
    {1'b1, 20'h00512, 16'h3333, 2'b11},
    {1'b1, 20'h00513, 16'h4444, 2'b11},
    {1'b0, 20'h00510, 16'h0000, 2'b00},
    {1'b1, 20'hFFEFC, 16'hA5A5, 2'b11},
    {1'b1, 20'hFFEFD, 16'h77FF, 2'b01},
    {1'b1, 20'hFFEFD, 16'h1234, 2'b10},
    {1'b0, 20'hFFEFC, 16'h0000, 2'b00},
    {1'b1, 20'h80100, 16'hBEEF, 2'b11},
    {1'b0, 20'h80100, 16'h0000, 2'b00},
    {1'b1, 20'h00511, 16'hFFFF, 2'b00},
    {1'b0, 20'h00510, 16'h0000, 2'b00},
    {1'b0, 20'hFFEFC, 16'h0000, 2'b00}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in;
  logic [0:0]  sd_ba;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;

  always #2 clk = ~clk;

  sdram_ctrl #(.CL(CL), .BL(BL), .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL),
               .T_RCD(T_RCD), .T_RP(T_RP), .T_RDL(T_RDL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm));

  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model (reduced array) ----------------
  logic [15:0] mem [0:2047];
  logic [10:0] open_row [0:1];
  logic [15:0] st_d [0:15];
  logic        st_v [0:15];
  logic [15:0] dq_drv = '0;
  logic        dq_drv_v = 0;
  assign sd_dq_in = dq_drv_v ? dq_drv : 16'h0000;

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) begin st_v[i] = 0; st_d[i] = '0; end
    open_row[0] = '0; open_row[1] = '0;
  end

  function automatic logic [7:0] burst_col(input logic [7:0] c, input int j);
    return (c & ~8'(BL - 1)) | ((c + 8'(j)) & 8'(BL - 1));
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 15; i++) begin st_v[i] = st_v[i+1]; st_d[i] = st_d[i+1]; end
    st_v[15] = 0;
    if (sd_cke && cmd == C_ACT) open_row[sd_ba] = sd_addr;
    if (sd_cke && cmd == C_WR) begin
      logic [10:0] ix;
      ix = {sd_ba, open_row[sd_ba][1:0], sd_addr[7:0]};
      if (!sd_dqm[0]) mem[ix][7:0]  = sd_dq_out[7:0];
      if (!sd_dqm[1]) mem[ix][15:8] = sd_dq_out[15:8];
    end
    if (sd_cke && cmd == C_RD) begin
      for (int j = 0; j < BL; j++) begin
        st_v[CL-1+j] = 1;
        st_d[CL-1+j] = mem[{sd_ba, open_row[sd_ba][1:0], burst_col(sd_addr[7:0], j)}];
      end
    end
    dq_drv   <= st_d[0];
    dq_drv_v <= st_v[0];
  end

  // ---------------- pin monitor ----------------
  int cyc = 0, rst_fall_cyc = 0, first_cmd_cyc = -1, n_init = 0;
  logic [3:0]  init_cmd [0:3];
  logic        init_a10 = 0;
  logic [10:0] mode_word = '0;
  logic [0:0]  mode_ba = '0;
  int last_act [0:1] = '{-1000, -1000};
  int last_pre [0:1] = '{-1000, -1000};
  int last_wr = -1000, last_preall = -1000, last_rd_cyc = 0, first_beat_cyc = 0;
  int n_ref = 0, last_ref = -1;
  bit act_since_preall = 0;
  logic [0:0]  act_ba = '0;
  logic [10:0] act_row = '0, rw_addr = '0;
  logic [0:0]  rw_ba = '0;
  logic [15:0] wr_dq = '0;
  logic [1:0]  wr_dqm = '0;
  logic [15:0] rd_buf [0:15];
  int rd_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && sd_cke && cmd != C_NOP) begin
      if (first_cmd_cyc < 0) first_cmd_cyc = cyc;
      if (n_init < 4) begin
        init_cmd[n_init] = cmd;
        if (n_init == 0) init_a10 = sd_addr[10];
        n_init++;
      end
      chk(sd_dq_oe == (cmd == C_WR), "R6 dq_oe vs command", sd_dq_oe, cmd == C_WR);
      case (cmd)
        C_MRS: begin mode_word = sd_addr; mode_ba = sd_ba; end
        C_ACT: begin
          chk(cyc - last_pre[sd_ba] >= T_RP, "R7 tRP before ACT", cyc - last_pre[sd_ba], T_RP);
          last_act[sd_ba] = cyc; act_ba = sd_ba; act_row = sd_addr; act_since_preall = 1;
        end
        C_RD, C_WR: begin
          chk(cyc - last_act[sd_ba] >= T_RCD, "R5 tRCD", cyc - last_act[sd_ba], T_RCD);
          rw_ba = sd_ba; rw_addr = sd_addr;
          if (cmd == C_WR) begin last_wr = cyc; wr_dq = sd_dq_out; wr_dqm = sd_dqm; end
          else last_rd_cyc = cyc;
        end
        C_PRE: begin
          chk(cyc - last_wr >= T_RDL, "R7 tRDL", cyc - last_wr, T_RDL);
          if (sd_addr[10]) begin
            last_pre[0] = cyc; last_pre[1] = cyc; last_preall = cyc; act_since_preall = 0;
          end else last_pre[sd_ba] = cyc;
        end
        C_REF: begin
          n_ref++;
          if (n_ref > 2) begin
            chk(cyc - last_preall >= T_RP && !act_since_preall, "R9 precharge-all before REF",
                cyc - last_preall, T_RP);
            if (last_ref >= 0)
              chk((cyc - last_ref >= REF_INTERVAL - SLACK) && (cyc - last_ref <= REF_INTERVAL + SLACK),
                  "R9 refresh interval", cyc - last_ref, REF_INTERVAL);
            last_ref = cyc;
          end
        end
        default: ;
      endcase
    end
    if (rd_valid) begin
      if (rd_cnt == 0) first_beat_cyc = cyc;
      if (rd_cnt < 16) rd_buf[rd_cnt] = rd_data;
      rd_cnt++;
    end
  end

  // ---------------- host side ----------------
  logic [15:0] shadow [int];

  function automatic logic [15:0] shadow_rd(input logic [19:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  task automatic do_req(input logic [38:0] v);
    logic we; logic [19:0] a; logic [15:0] d; logic [1:0] be;
    {we, a, d, be} = v;
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (we) begin
      logic [15:0] o;
      o = shadow_rd(a);
      if (be[0]) o[7:0]  = d[7:0];
      if (be[1]) o[15:8] = d[15:8];
      shadow[int'(a)] = o;
    end else begin
      while (rd_cnt < BL) @(negedge clk);
    end
    while (!req_ready) @(negedge clk);
    chk(act_ba == a[19] && act_row == a[18:8], "R4 ACT bank/row", {act_ba, act_row}, a[19:8]);
    chk(rw_ba == a[19] && rw_addr[7:0] == a[7:0] && !rw_addr[10], "R4 column command address",
        {rw_ba, rw_addr}, {a[19], 3'b000, a[7:0]});
    if (we) begin
      if (be != 2'b00) chk(wr_dq == d, "R6 write data", wr_dq, d);
      chk(wr_dqm == ~be, "R6 dqm", wr_dqm, ~be);
    end else begin
      chk(rd_cnt == BL, "R8 beat count", rd_cnt, BL);
      chk(first_beat_cyc - last_rd_cyc == CL + 1, "R8 CAS latency", first_beat_cyc - last_rd_cyc, CL + 1);
      for (int j = 0; j < BL; j++) begin
        logic [19:0] aj;
        aj = {a[19:8], burst_col(a[7:0], j)};
        chk(rd_buf[j] == shadow_rd(aj), "R8/R11 read data", rd_buf[j], shadow_rd(aj));
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int ref_before;
    repeat (4) @(negedge clk);
    chk(!sd_cke && cmd == C_NOP && !req_ready && !rd_valid, "R1 reset state",
        {sd_cke, cmd, req_ready, rd_valid}, {1'b0, C_NOP, 2'b00});
    rst = 0;
    rst_fall_cyc = cyc;
    @(negedge clk);
    chk(cmd == C_NOP && !req_ready && !rd_valid, "R1 first cycle after reset",
        {cmd, req_ready, rd_valid}, {C_NOP, 2'b00});
    while (!req_ready) @(negedge clk);
    chk(n_init == 4, "R2 command count before ready", n_init, 4);
    chk(init_cmd[0] == C_PRE && init_a10, "R2 precharge-all first", {init_cmd[0], init_a10}, {C_PRE, 1'b1});
    chk(init_cmd[1] == C_REF && init_cmd[2] == C_REF, "R2 two refreshes",
        {init_cmd[1], init_cmd[2]}, {C_REF, C_REF});
    chk(init_cmd[3] == C_MRS, "R2 mode set last", init_cmd[3], C_MRS);
    chk(first_cmd_cyc - rst_fall_cyc >= INIT_WAIT, "R2 power-up wait",
        first_cmd_cyc - rst_fall_cyc, INIT_WAIT);
    chk(mode_word == {1'b0, 1'b1, 2'b00, 3'(CL), 1'b0, 3'd2} && mode_ba == 0, "R3 mode word",
        {mode_ba, mode_word}, {1'b0, 1'b0, 1'b1, 2'b00, 3'(CL), 1'b0, 3'd2});

    for (int i = 0; i < NV; i++) do_req(VEC[i]);

    ref_before = n_ref;
    for (int k = 0; k < 160; k++) do_req(VEC[(k % 2 == 0) ? 4 : 8]);
    chk(n_ref > ref_before, "R10 refresh served under back-to-back requests", n_ref - ref_before, 1);

    ref_before = n_ref;
    repeat (REF_INTERVAL + 100) @(negedge clk);
    chk(n_ref > ref_before, "R9 refresh while idle", n_ref - ref_before, 1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule